// File: doc/BRIEF.md
# Raster-Op Word Unit

This block handles one bit plane of a raster-operation engine. Software first loads a small register set through a write port: two source words, a pattern word, two edge masks, a shift control, an 8-bit function code, a span width and a line count. A start strobe then opens a span. Each step presents one destination word. The unit aligns the source across a word boundary with a funnel shifter and combines source, destination and a mask term through the function code, used as a truth table. One cycle later it returns one result word, with flags that mark the first and last word of each line.

After each accepted step, the right source word moves into the left source slot. Software loads only the next right word before the following step. When the last word of the last line has been produced, the unit drops busy and raises done. Done stays high until the next start. A status output reports whether the current function code depends on the mask term at all, so that a caller can skip mask setup.

Top module: `rop_word_unit`

## Requirements
- R1: After a synchronous active-low reset, res_out is zero and res_valid, first_word, last_word, busy, done and needs_mask are low. The source, mask, shift, function, width and count registers are zero, and the pattern register is all ones.
- R2: Each result bit i equals bit `{m[i], s[i], d[i]}` of the function code, where m is the mask term, s the aligned source and d the destination (bit 2 mask, bit 1 source, bit 0 destination). So 0xCC returns the source, 0xAA the destination and 0xF0 the mask term.
- R3: The aligned source is taken from the 32-bit concatenation {left source, right source}. Shift bit 8 selects direction and bits 3:0 the amount n. With direction 0 the source is the low 16 bits of the concatenation shifted right by n. With direction 1 it is the high 16 bits of the concatenation shifted left by n.
- R4: The mask term is the edge mask ANDed with the pattern register. The edge mask is the left mask on a line's first word, the right mask on its last word, their AND when a line is one word, and all ones for the middle words.
- R5: A step taken while busy produces res_valid high with its result exactly one clock later. res_valid is otherwise low.
- R6: Every accepted step copies the right source into the left source. A write to the right source in a later cycle supplies the next word.
- R7: Each line holds width+1 words and the span holds count+1 lines (width and count taken from the low 8 bits of their registers at start). first_word and last_word go high with the first and last result of every line.
- R8: done rises together with the final result of the final line, busy falls at the same edge, and done holds until a start. A start clears done and sets busy one clock later.
- R9: A step while not busy is ignored. No result appears, and the source registers do not move.
- R10: needs_mask is high exactly when the upper nibble of the function code differs from its lower nibble.
- R11: Register select codes on cfg_sel are 0 left source, 1 right source, 2 pattern, 3 left mask, 4 right mask, 5 shift, 6 function, 7 width and 8 count. A write takes effect at the clock edge where cfg_we is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 4 | Register select code |
| cfg_wdata | input | 16 | Register write data |
| start | input | 1 | Opens a new span |
| step | input | 1 | Consume dst_in and produce one word |
| dst_in | input | 16 | Destination word for this step |
| res_out | output | 16 | Result word |
| res_valid | output | 1 | res_out holds a new word |
| first_word | output | 1 | Result is the first word of a line |
| last_word | output | 1 | Result is the last word of a line |
| busy | output | 1 | A span is in progress |
| done | output | 1 | Span finished; held until start |
| needs_mask | output | 1 | Function code depends on the mask term |

## Verification
A result, together with its first/last flags and the done flag of a span's final word, is due one clock edge after the step that caused it. The bench drives a step on a falling edge, lets one rising edge pass and samples on the next falling edge. A register write or start takes effect at the single rising edge between two falling edges, so needs_mask and the cleared done are sampled one falling edge after the write or start. The bench computes the expected words from its own model of the source chain, the funnel and the truth table, and sweeps all 256 function codes and all 32 shift settings.

// File: rtl/rop_pkg.sv
`timescale 1ns/1ps
// Package: shared constants for the raster-op word unit.
// Assumes register select codes are fixed by the software view (R11).
package rop_pkg;
    localparam logic [3:0] SEL_SRC_L  = 4'd0;
    localparam logic [3:0] SEL_SRC_R  = 4'd1;
    localparam logic [3:0] SEL_PAT    = 4'd2;
    localparam logic [3:0] SEL_MASK_L = 4'd3;
    localparam logic [3:0] SEL_MASK_R = 4'd4;
    localparam logic [3:0] SEL_SHIFT  = 4'd5;
    localparam logic [3:0] SEL_FUNC   = 4'd6;
    localparam logic [3:0] SEL_WIDTH  = 4'd7;
    localparam logic [3:0] SEL_COUNT  = 4'd8;
    localparam int         DIR_BIT    = 8;
endpackage

// File: rtl/rop_funnel.sv
`timescale 1ns/1ps
// Module: funnel shifter. Joins left and right source words and picks one
// word at a bit offset, toward the right (dir_left=0) or left (dir_left=1).
// Assumes W is a power of two and amt spans 0..W-1.
module rop_funnel #(
    parameter int W    = 16,
    parameter int SH_W = $clog2(W)
) (
    input  logic [W-1:0]    left_w,
    input  logic [W-1:0]    right_w,
    input  logic [SH_W-1:0] amt,
    input  logic            dir_left,
    output logic [W-1:0]    aligned
);
    localparam int CAT_W = 2 * W;

    logic [CAT_W-1:0] cat;
    logic [CAT_W-1:0] rsh;
    logic [CAT_W-1:0] lsh;

    // Purpose: build both shifted candidates and select by direction.
    always_comb begin
        cat = {left_w, right_w};
        rsh = cat >> amt;
        lsh = cat << amt;
        aligned = dir_left ? lsh[CAT_W-1:W] : rsh[W-1:0];
    end

    // Purpose: a zero shift must pass one source word through untouched.
    always_comb begin
        if (amt == '0) begin
            assert_zero_shift_R3: assert (aligned == (dir_left ? left_w : right_w));
        end
    end
endmodule

// File: rtl/rop_minterm.sv
`timescale 1ns/1ps
// Module: truth-table combiner. Each output bit indexes the function code
// with {mask, source, destination} bits of the same position.
// Assumes an 8-entry table (three inputs per bit).
module rop_minterm #(
    parameter int W = 16
) (
    input  logic [7:0]   func,
    input  logic [W-1:0] mask_t,
    input  logic [W-1:0] src,
    input  logic [W-1:0] dst,
    output logic [W-1:0] res
);
    // Purpose: one table lookup per bit position.
    for (genvar gi = 0; gi < W; gi++) begin : g_bit
        assign res[gi] = func[{mask_t[gi], src[gi], dst[gi]}];
    end

    // Purpose: the three basis codes must select their own operand.
    always_comb begin
        if (func == 8'hCC) begin
            assert_basis_src_R2: assert (res == src);
        end
        if (func == 8'hAA) begin
            assert_basis_dst_R2: assert (res == dst);
        end
        if (func == 8'hF0) begin
            assert_basis_mask_R2: assert (res == mask_t);
        end
    end
endmodule

// File: rtl/rop_span_ctrl.sv
`timescale 1ns/1ps
// Module: span sequencer. Counts words within a line and lines within a
// span, flags line edges for the current step and holds done until start.
// Assumes width and count mean "number minus one" and start wins over step.
module rop_span_ctrl #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             step,
    input  logic [CNT_W-1:0] width,
    input  logic [CNT_W-1:0] count,
    output logic             accept,
    output logic             is_first,
    output logic             is_last,
    output logic             busy,
    output logic             done
);
    logic [CNT_W-1:0] word_cnt;
    logic [CNT_W-1:0] line_cnt;
    logic [CNT_W-1:0] width_q;

    // Purpose: a step counts only inside an active span.
    always_comb begin
        accept   = step && busy && !start;
        is_first = (word_cnt == width_q);
        is_last  = (word_cnt == '0);
    end

    // Purpose: load counters on start, walk words and lines on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            word_cnt <= '0;
            line_cnt <= '0;
            width_q  <= '0;
        end else if (start) begin
            busy     <= 1'b1;
            done     <= 1'b0;
            word_cnt <= width;
            line_cnt <= count;
            width_q  <= width;
        end else if (accept) begin
            if (word_cnt == '0) begin
                if (line_cnt == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    line_cnt <= line_cnt - 1'b1;
                    word_cnt <= width_q;
                end
            end else begin
                word_cnt <= word_cnt - 1'b1;
            end
        end
    end

    // Purpose: word counter never leaves the line range while active.
    assert_cnt_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (word_cnt <= width_q));

    // Purpose: busy and done never overlap.
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // Purpose: start always opens a span on the next edge.
    assert_start_opens_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && !done));
endmodule

// File: rtl/rop_word_unit.sv
`timescale 1ns/1ps
// Module: single-plane raster-op word unit (top). Holds the register set,
// aligns the source with a funnel, forms the edge/pattern mask term and
// evaluates the function code, registering one result word per step.
// Assumes WORD_W > DIR_BIT so the direction bit fits in the shift register.
module rop_word_unit
    import rop_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_sel,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              start,
    input  logic              step,
    input  logic [WORD_W-1:0] dst_in,
    output logic [WORD_W-1:0] res_out,
    output logic              res_valid,
    output logic              first_word,
    output logic              last_word,
    output logic              busy,
    output logic              done,
    output logic              needs_mask
);
    localparam int SH_W = $clog2(WORD_W);

    logic [WORD_W-1:0] src_l, src_r, pat_q, mask_l, mask_r;
    logic [SH_W-1:0]   sh_amt;
    logic              sh_left;
    logic [7:0]        func_q;
    logic [CNT_W-1:0]  width_q, count_q;

    logic              accept, is_first, is_last;
    logic [WORD_W-1:0] aligned, edge_m, mask_term, comb_res;

    // Purpose: register writes plus the left-from-right source chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_l   <= '0;
            src_r   <= '0;
            pat_q   <= '1;
            mask_l  <= '0;
            mask_r  <= '0;
            sh_amt  <= '0;
            sh_left <= 1'b0;
            func_q  <= '0;
            width_q <= '0;
            count_q <= '0;
        end else begin
            if (accept) begin
                src_l <= src_r;
            end
            if (cfg_we) begin
                case (cfg_sel)
                    SEL_SRC_L:  src_l  <= cfg_wdata;
                    SEL_SRC_R:  src_r  <= cfg_wdata;
                    SEL_PAT:    pat_q  <= cfg_wdata;
                    SEL_MASK_L: mask_l <= cfg_wdata;
                    SEL_MASK_R: mask_r <= cfg_wdata;
                    SEL_SHIFT: begin
                        sh_amt  <= cfg_wdata[SH_W-1:0];
                        sh_left <= cfg_wdata[DIR_BIT];
                    end
                    SEL_FUNC:   func_q  <= cfg_wdata[7:0];
                    SEL_WIDTH:  width_q <= cfg_wdata[CNT_W-1:0];
                    SEL_COUNT:  count_q <= cfg_wdata[CNT_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    rop_span_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .step     (step),
        .width    (width_q),
        .count    (count_q),
        .accept   (accept),
        .is_first (is_first),
        .is_last  (is_last),
        .busy     (busy),
        .done     (done)
    );

    rop_funnel #(.W(WORD_W), .SH_W(SH_W)) u_funnel (
        .left_w   (src_l),
        .right_w  (src_r),
        .amt      (sh_amt),
        .dir_left (sh_left),
        .aligned  (aligned)
    );

    // Purpose: pick the edge mask for this word and fold in the pattern.
    always_comb begin
        case ({is_first, is_last})
            2'b11:   edge_m = mask_l & mask_r;
            2'b10:   edge_m = mask_l;
            2'b01:   edge_m = mask_r;
            default: edge_m = '1;
        endcase
        mask_term = edge_m & pat_q;
    end

    rop_minterm #(.W(WORD_W)) u_minterm (
        .func   (func_q),
        .mask_t (mask_term),
        .src    (aligned),
        .dst    (dst_in),
        .res    (comb_res)
    );

    // Purpose: register the result word and its line-edge flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_out    <= '0;
            res_valid  <= 1'b0;
            first_word <= 1'b0;
            last_word  <= 1'b0;
        end else begin
            res_valid  <= accept;
            first_word <= accept && is_first;
            last_word  <= accept && is_last;
            if (accept) begin
                res_out <= comb_res;
            end
        end
    end

    // Purpose: report whether the code's value depends on the mask bit.
    assign needs_mask = (func_q[7:4] != func_q[3:0]);

    // Purpose: a result appears only one edge after a step in a span.
    assert_valid_after_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(step && busy));

    // Purpose: line-edge flags travel only with a result.
    assert_flags_need_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (first_word || last_word) |-> res_valid);

    // Purpose: done rises together with the last word of a line.
    assert_done_with_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (res_valid && last_word));

    // Purpose: an accepted step hands the right source to the left slot.
    assert_chain_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !(cfg_we && cfg_sel == SEL_SRC_L)) |=> (src_l == $past(src_r)));

    // Purpose: idle steps produce nothing.
    assert_idle_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !busy) |=> !res_valid);
endmodule

// File: tb/rop_word_unit_bench.sv
`timescale 1ns/1ps
// Bench: sweeps function codes and shift settings on one-word spans, then
// runs a multi-line span and checks edge masks, chaining, done and idle steps.
module rop_word_unit_bench;
    localparam logic [3:0] S_SL = 4'd0, S_SR = 4'd1, S_PAT = 4'd2, S_ML = 4'd3,
                           S_MR = 4'd4, S_SH = 4'd5, S_FN = 4'd6, S_WD = 4'd7,
                           S_CT = 4'd8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [3:0] cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic start = 1'b0;
    logic step = 1'b0;
    logic [15:0] dst_in = '0;
    logic [15:0] res_out;
    logic res_valid, first_word, last_word, busy, done, needs_mask;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [15:0] l_m, r_m;

    always #10 clk = ~clk;

    rop_word_unit u_rop_word_unit (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .start(start), .step(step), .dst_in(dst_in),
        .res_out(res_out), .res_valid(res_valid), .first_word(first_word),
        .last_word(last_word), .busy(busy), .done(done), .needs_mask(needs_mask)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] sel, input logic [15:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic go();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Result is registered: sampled on the falling edge after the capturing edge.
    task automatic stp(input logic [15:0] d);
        @(negedge clk);
        step = 1'b1; dst_in = d;
        @(negedge clk);
        step = 1'b0;
    endtask

    function automatic logic [15:0] rop_eval(input logic [7:0] f, input logic [15:0] m,
                                             input logic [15:0] s, input logic [15:0] d);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) begin
            r[i] = f[m[i] * 4 + s[i] * 2 + d[i]];
        end
        return r;
    endfunction

    function automatic logic [15:0] fun(input logic [15:0] l, input logic [15:0] r,
                                        input int n, input bit lft);
        longint unsigned cat;
        cat = {48'd0, l, r};
        if (lft) return 16'((cat * (64'd1 << n)) / 64'd65536);
        return 16'((cat / (64'd1 << n)) % 64'd65536);
    endfunction

    initial begin
        repeat (400000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 res_out", 32'(res_out), 0);
        chk("R1 flags", {26'd0, res_valid, first_word, last_word, busy, done, needs_mask}, 0);

        // R10, R11: needs_mask over every function code
        for (int f = 0; f < 256; f++) begin
            wr(S_FN, 16'(f));
            chk("R10 needs_mask", 32'(needs_mask), 32'(((f >> 4) & 15) != (f & 15)));
        end

        // R2: truth table, one-word span, mask term = 0xFF00
        wr(S_WD, 0); wr(S_CT, 0); wr(S_ML, 16'hFF00); wr(S_MR, 16'hFFFF);
        wr(S_SH, 0); wr(S_SR, 16'hF0F0);
        for (int f = 0; f < 256; f++) begin
            wr(S_FN, 16'(f));
            go();
            stp(16'hCCCC);
            chk("R2 result", 32'(res_out), 32'(rop_eval(8'(f), 16'hFF00, 16'hF0F0, 16'hCCCC)));
            if (f == 0 || f == 255) begin
                chk("R5 valid", 32'(res_valid), 1);
                chk("R7 single-word first/last", {30'd0, first_word, last_word}, 3);
                chk("R8 done", {30'd0, busy, done}, 1);
            end
        end

        // R3: all shift amounts and directions, source-only code
        wr(S_FN, 16'h00CC); wr(S_ML, 16'hFFFF);
        for (int dir = 0; dir < 2; dir++) begin
            for (int n = 0; n < 16; n++) begin
                wr(S_SL, 16'hA5C3); wr(S_SR, 16'h5E17);
                wr(S_SH, 16'((dir << 8) | n));
                go();
                stp(16'h0000);
                chk("R3 funnel", 32'(res_out), 32'(fun(16'hA5C3, 16'h5E17, n, dir[0])));
            end
        end

        // R4, R6, R7, R8: two lines of four words, code 0xCA = mask ? src : dst
        wr(S_FN, 16'h00CA); wr(S_ML, 16'h0FFF); wr(S_MR, 16'hFFF0);
        wr(S_SH, 16'h0004); wr(S_WD, 3); wr(S_CT, 1);
        l_m = 16'h9ABC;
        wr(S_SL, l_m);
        go();
        chk("R8 start clears done", {30'd0, busy, done}, 2);
        for (int k = 0; k < 8; k++) begin
            logic [15:0] s, e, d, x;
            int w;
            w = k % 4;
            r_m = 16'h1357 * 16'(k + 1);
            wr(S_SR, r_m);
            s = fun(l_m, r_m, 4, 1'b0);
            e = (w == 0) ? 16'h0FFF : (w == 3) ? 16'hFFF0 : 16'hFFFF;
            d = 16'h3C3C + 16'(k * 7);
            x = (e & s) | (~e & d);
            stp(d);
            chk("R4 R6 span result", 32'(res_out), 32'(x));
            chk("R7 first/last", {30'd0, first_word, last_word},
                {30'd0, w == 0, w == 3});
            chk("R8 done", {30'd0, busy, done}, (k == 7) ? 1 : 2);
            l_m = r_m;
        end
        repeat (5) @(negedge clk);
        chk("R8 done sticky", 32'(done), 1);

        // R9: idle step ignored, sources not moved
        r_m = 16'h0F1E;
        wr(S_SR, r_m);
        stp(16'h1234);
        chk("R9 no result", 32'(res_valid), 0);
        wr(S_WD, 0); wr(S_CT, 0); wr(S_SH, 16'h0108); wr(S_ML, 16'hFFFF); wr(S_MR, 16'hFFFF);
        go();
        stp(16'h0000);
        chk("R9 sources unmoved", 32'(res_out), 32'(fun(l_m, r_m, 8, 1'b1)));

        // R4: pattern joins the mask term
        wr(S_PAT, 16'h0F0F); wr(S_SH, 0); wr(S_SR, 16'hAAAA);
        go();
        stp(16'h5555);
        chk("R4 pattern", 32'(res_out), 32'((16'h0F0F & 16'hAAAA) | (16'hF0F0 & 16'h5555)));

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule